// File: doc/BRIEF.md
# Digital Line Bank with Per-Line Interrupt Qualification

This block looks after a bank of general-purpose digital lines. Each line can be set to input or output. An output line works as open-drain: it either pulls the pin low or lets it go, so several drivers can share one wire. Software reads and writes the block through a synchronous register bus with 16-bit words. Each register that covers all the lines spans consecutive word addresses.

Every line can raise an interrupt, whatever its direction. The pin level passes through a two-stage synchronizer. It is then qualified by a per-line invert bit, so the line can be active high or active low. A per-line mode bit picks how the status bit behaves. In edge mode, a rising edge of the qualified level sets a sticky status bit, which software clears by writing ones to it. In level mode, the status bit simply mirrors the qualified level. A single interrupt output is the OR of all status bits whose enable bit is set.

Top module: `dio_irq_ctrl`

## Requirements
- R1: After synchronous reset, every register word reads 0, `drv_low` is all zeros and `irq` is 0.
- R2: The direction (word addresses 0..2), output-data (3..5), enable (9..11), invert (12..14) and mode (15..17) words read back the last value written. Word w of a group holds lines 16w to 16w+15, and bit b of that word is line 16w+b.
- R3: `drv_low[i]` is 1 exactly when line i is an output (direction bit 1) whose output-data bit is 0. The value follows a register write by one cycle, and a 1 means the pin is pulled low.
- R4: The input words (addresses 6..8) return the pin levels after a two-stage synchronizer. A pin change made before edge E first shows in a read issued at edge E+2. Writes to these words have no effect.
- R5: With mode bit 1 (edge), an inactive-to-active transition of the qualified level sets the line's status bit (addresses 18..20). The bit stays set after the line goes inactive again.
- R6: With invert bit 0, the qualified level equals the pin (active high). With invert bit 1, it is the inverted pin (active low).
- R7: Writing a status word clears each edge-mode status bit whose written bit is 1. Bits written as 0 are left unchanged.
- R8: With mode bit 0 (level), the status bit equals the qualified level one cycle later. It is not latched, and writing 1 to it does not clear it.
- R9: `irq` is 1 exactly when some status bit is 1 and its enable bit is also 1. It is registered one cycle after the status.
- R10: Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds while no read is issued. Unmapped addresses (21 and above) read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one word |
| bus_rd | input | 1 | Read strobe for one word |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pad_in | input | 48 | Level seen on each line pin |
| drv_low | output | 48 | 1 pulls the pin low, 0 releases it |
| irq | output | 1 | Combined interrupt request |

## Verification
The qualification path is tried with several patterns, each aimed at one possible fault:
- A single rising pulse on an edge-mode line separates sticky latching from level tracking.
- The same pulse on an inverted line shows whether the invert bit is applied before edge detection, since only the falling pin edge may set the bit.
- Level-mode lines are toggled while a clear is written, which exposes any latching in that mode.
- Partial clear masks confirm that W1C touches only the selected bits.
- Enable masks are switched while a status bit stays set, which separates gating by the enable from gating by the status.
- The synchronizer delay is pinned by reads at exactly two and three edges after a pin change.
- Mixed direction and data patterns in separate words catch a swapped open-drain term.

// File: rtl/dio_pkg.sv
package dio_pkg;
  // register groups; each spans NUM_LINES/DATA_W consecutive words
  typedef enum logic [2:0] {
    GRP_DIR  = 3'd0,
    GRP_OUT  = 3'd1,
    GRP_IN   = 3'd2,
    GRP_IEN  = 3'd3,
    GRP_INV  = 3'd4,
    GRP_MODE = 3'd5,
    GRP_STAT = 3'd6
  } grp_e;
  localparam int NUM_GRP = 7;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int WIDTH = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dio_status.sv
module dio_status #(
  parameter int NUM_LINES = 48
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lvl,
  input  logic [NUM_LINES-1:0] inv,
  input  logic [NUM_LINES-1:0] mode,
  input  logic [NUM_LINES-1:0] clr,
  output logic [NUM_LINES-1:0] stat
);
  logic [NUM_LINES-1:0] act;
  logic [NUM_LINES-1:0] act_d;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign act[i] = lvl[i] ^ inv[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        act_d[i] <= 1'b0;
        stat[i]  <= 1'b0;
      end else begin
        act_d[i] <= act[i];
        if (mode[i]) begin
          // edge: new event wins over a clear in the same cycle
          stat[i] <= (act[i] & ~act_d[i]) | (stat[i] & ~clr[i]);
        end else begin
          stat[i] <= act[i];
        end
      end
    end
  end
endmodule

// File: rtl/dio_regs.sv
module dio_regs
  import dio_pkg::*;
#(
  parameter int NUM_LINES = 48,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic [NUM_LINES-1:0] in_sync,
  input  logic [NUM_LINES-1:0] stat,
  output logic [NUM_LINES-1:0] dir,
  output logic [NUM_LINES-1:0] odat,
  output logic [NUM_LINES-1:0] ien,
  output logic [NUM_LINES-1:0] inv,
  output logic [NUM_LINES-1:0] mode,
  output logic [NUM_LINES-1:0] clr
);
  localparam int WORDS = NUM_LINES / DATA_W;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int grp, input int w);
    return a == ADDR_W'(grp * WORDS + w);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      dir  <= '0;
      odat <= '0;
      ien  <= '0;
      inv  <= '0;
      mode <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < WORDS; w++) begin
        if (hit(addr, int'(GRP_DIR), w))  dir[w*DATA_W +: DATA_W]  <= wdata;
        if (hit(addr, int'(GRP_OUT), w))  odat[w*DATA_W +: DATA_W] <= wdata;
        if (hit(addr, int'(GRP_IEN), w))  ien[w*DATA_W +: DATA_W]  <= wdata;
        if (hit(addr, int'(GRP_INV), w))  inv[w*DATA_W +: DATA_W]  <= wdata;
        if (hit(addr, int'(GRP_MODE), w)) mode[w*DATA_W +: DATA_W] <= wdata;
      end
    end
  end

  // write-one-to-clear pulse toward the status logic
  always_comb begin
    clr = '0;
    if (wr_en) begin
      for (int w = 0; w < WORDS; w++) begin
        if (hit(addr, int'(GRP_STAT), w)) clr[w*DATA_W +: DATA_W] = wdata;
      end
    end
  end

  logic [NUM_LINES-1:0] grp_vec [NUM_GRP];
  assign grp_vec[GRP_DIR]  = dir;
  assign grp_vec[GRP_OUT]  = odat;
  assign grp_vec[GRP_IN]   = in_sync;
  assign grp_vec[GRP_IEN]  = ien;
  assign grp_vec[GRP_INV]  = inv;
  assign grp_vec[GRP_MODE] = mode;
  assign grp_vec[GRP_STAT] = stat;

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      for (int w = 0; w < WORDS; w++) begin
        if (hit(addr, g, w)) rd_mux = grp_vec[g][w*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dio_irq_ctrl.sv
module dio_irq_ctrl #(
  parameter int NUM_LINES = 48,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] drv_low,
  output logic                 irq
);
  logic [NUM_LINES-1:0] in_sync;
  logic [NUM_LINES-1:0] dir_r, odat_r, ien_r, inv_r, mode_r, clr_w, stat_r;

  dio_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (in_sync)
  );

  dio_regs #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr),
    .rd_en   (bus_rd),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .in_sync (in_sync),
    .stat    (stat_r),
    .dir     (dir_r),
    .odat    (odat_r),
    .ien     (ien_r),
    .inv     (inv_r),
    .mode    (mode_r),
    .clr     (clr_w)
  );

  dio_status #(.NUM_LINES(NUM_LINES)) u_stat (
    .clk  (clk),
    .rst  (rst),
    .lvl  (in_sync),
    .inv  (inv_r),
    .mode (mode_r),
    .clr  (clr_w),
    .stat (stat_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_low <= '0;
      irq     <= 1'b0;
    end else begin
      drv_low <= dir_r & ~odat_r;
      irq     <= |(stat_r & ien_r);
    end
  end
endmodule

// File: rtl/dio_irq_ctrl_chk.sv
module dio_irq_ctrl_chk #(
  parameter int NUM_LINES = 48,
  parameter int DATA_W    = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_rd,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [NUM_LINES-1:0] drv_low,
  input logic                 irq,
  input logic [NUM_LINES-1:0] dir_q,
  input logic [NUM_LINES-1:0] ien_q,
  input logic [NUM_LINES-1:0] inv_q,
  input logic [NUM_LINES-1:0] mode_q,
  input logic [NUM_LINES-1:0] clr_q,
  input logic [NUM_LINES-1:0] stat_q,
  input logic [NUM_LINES-1:0] sync_q
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (drv_low == '0 && !irq));

  assert_drive_only_outputs_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((drv_low & ~$past(dir_q)) == '0));

  assert_edge_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(stat_q & mode_q & ~clr_q) & ~stat_q) == '0));

  assert_level_follows_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((stat_q ^ $past(sync_q ^ inv_q)) & ~$past(mode_q)) == '0));

  assert_irq_needs_source_R9: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ien_q) == '0) |=> !irq);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind dio_irq_ctrl dio_irq_ctrl_chk #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .drv_low   (drv_low),
  .irq       (irq),
  .dir_q     (dir_r),
  .ien_q     (ien_r),
  .inv_q     (inv_r),
  .mode_q    (mode_r),
  .clr_q     (clr_w),
  .stat_q    (stat_r),
  .sync_q    (in_sync)
);

// File: tb/tb_dio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_dio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [47:0] pad_in;
  logic [47:0] drv_low;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] q_exp [$];
  string       q_tag [$];
  logic        pend = 1'b0;

  always #2.5 clk = ~clk;

  dio_irq_ctrl dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .drv_low(drv_low), .irq(irq)
  );

  // monitor: a read strobed at an edge is compared at the following falling edge
  always @(posedge clk) pend <= bus_rd;
  always @(negedge clk) begin
    if (pend) begin
      checks++;
      if (q_exp.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected read data %h, expected no data", bus_rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: read %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, input logic [15:0] e, input string t);
    bus_rd = 1'b1; bus_addr = a;
    q_exp.push_back(e);
    q_tag.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(input logic [47:0] act, input logic [47:0] e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(1);

    // R1 reset state
    chk(drv_low, 48'h0, "R1 drv_low");
    chk({47'h0, irq}, 48'h0, "R1 irq");
    for (int a = 0; a < 21; a++) bus_read(5'(a), 16'h0, "R1");

    // R2 control readback
    for (int a = 0; a < 18; a++) begin
      if (a < 6 || a > 8) bus_write(5'(a), 16'h3C00 ^ (16'(a) * 16'h0111));
    end
    for (int a = 0; a < 18; a++) begin
      if (a < 6 || a > 8) bus_read(5'(a), 16'h3C00 ^ (16'(a) * 16'h0111), "R2");
    end
    for (int a = 0; a < 18; a++) begin
      if (a < 6 || a > 8) bus_write(5'(a), 16'h0);
    end
    for (int a = 18; a < 21; a++) bus_write(5'(a), 16'hFFFF);
    wait_cyc(2);
    for (int a = 18; a < 21; a++) bus_read(5'(a), 16'h0, "R2 status idle");

    // R10 unmapped addresses
    bus_write(5'd21, 16'hFFFF);
    bus_read(5'd21, 16'h0, "R10 unmapped 21");
    bus_read(5'd31, 16'h0, "R10 unmapped 31");

    // R3 open-drain drive
    bus_write(5'd0, 16'h00FF);
    bus_write(5'd3, 16'h0F0F);
    bus_write(5'd2, 16'hFFFF);
    bus_write(5'd5, 16'h00FF);
    wait_cyc(2);
    chk(drv_low, {16'hFF00, 16'h0000, 16'h00F0}, "R3 drv_low");
    bus_write(5'd3, 16'hFFFF);
    wait_cyc(2);
    chk(drv_low, {16'hFF00, 16'h0000, 16'h0000}, "R3 release");

    // R4 synchronizer latency and input readback
    pad_in = 48'h1234_5678_9ABC;
    wait_cyc(1);
    bus_read(5'd6, 16'h0000, "R4 two-edge latency old");
    bus_read(5'd6, 16'h9ABC, "R4 third edge new");
    bus_read(5'd7, 16'h5678, "R4 word1");
    bus_read(5'd8, 16'h1234, "R4 word2");
    bus_write(5'd6, 16'hFFFF);
    bus_read(5'd6, 16'h9ABC, "R4 write ignored");
    pad_in = '0;
    wait_cyc(4);

    // R5 edge sticky on word0
    bus_write(5'd9, 16'hFFFF);
    bus_write(5'd15, 16'hFFFF);
    pad_in[0] = 1'b1;
    wait_cyc(6);
    bus_read(5'd18, 16'h0001, "R5 edge set");
    chk({47'h0, irq}, 48'h1, "R9 irq on edge status");
    pad_in[0] = 1'b0;
    wait_cyc(6);
    bus_read(5'd18, 16'h0001, "R5 sticky after release");

    // R6 invert on line 1
    bus_write(5'd12, 16'h0002);
    wait_cyc(3);
    bus_write(5'd18, 16'hFFFF);
    wait_cyc(2);
    bus_read(5'd18, 16'h0000, "R7 clear all");
    pad_in[1] = 1'b1;
    wait_cyc(6);
    bus_read(5'd18, 16'h0000, "R6 rising pin inactive when inverted");
    pad_in[1] = 1'b0;
    wait_cyc(6);
    bus_read(5'd18, 16'h0002, "R6 falling pin active when inverted");

    // R7 partial clear
    pad_in[0] = 1'b1;
    wait_cyc(6);
    pad_in[0] = 1'b0;
    wait_cyc(6);
    bus_read(5'd18, 16'h0003, "R7 two set");
    bus_write(5'd18, 16'h0001);
    wait_cyc(1);
    bus_read(5'd18, 16'h0002, "R7 only written one cleared");
    chk({47'h0, irq}, 48'h1, "R9 irq held");
    bus_write(5'd18, 16'h0002);
    wait_cyc(3);
    chk({47'h0, irq}, 48'h0, "R9 irq drops");

    // R5 upper line 47
    bus_write(5'd17, 16'h8000);
    bus_write(5'd11, 16'h8000);
    pad_in[47] = 1'b1;
    wait_cyc(6);
    bus_read(5'd20, 16'h8000, "R5 line 47");
    pad_in[47] = 1'b0;
    bus_write(5'd11, 16'h0000);
    bus_write(5'd20, 16'hFFFF);
    wait_cyc(4);

    // R8 level mode on word1, enable off first (R9 masking)
    pad_in[16] = 1'b1;
    wait_cyc(6);
    bus_read(5'd19, 16'h0001, "R8 level follows");
    chk({47'h0, irq}, 48'h0, "R9 masked by enable");
    bus_write(5'd10, 16'h0001);
    wait_cyc(2);
    chk({47'h0, irq}, 48'h1, "R9 enabled");
    bus_write(5'd19, 16'hFFFF);
    wait_cyc(1);
    bus_read(5'd19, 16'h0001, "R8 not cleared by write");
    pad_in[16] = 1'b0;
    wait_cyc(6);
    bus_read(5'd19, 16'h0000, "R8 not latched");
    chk({47'h0, irq}, 48'h0, "R9 irq follows level");
    bus_write(5'd13, 16'h0002);
    wait_cyc(3);
    bus_read(5'd19, 16'h0002, "R6 inverted level active low");

    wait_cyc(4);
    if (q_exp.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R10: %0d reads without data, expected 0", q_exp.size());
    end
    finish_run();
  end
endmodule